// File: doc/BRIEF.md
# Store Buffer with Partial-Key Load Forwarding

This block sits between a core's retirement stage and the write port of a first-level data cache. Retired stores are written into a small circular buffer. A store counts as complete as soon as it is accepted, so it adds no latency while the buffer has room. The buffer then writes its stores to the cache one at a time, oldest first, whenever the cache's write port is ready.

Younger loads probe the buffer so that they never read stale data from the cache. The first check is cheap: it compares a 12-bit slice of each address, the word-address bits [13:2], against every held store. If no slice matches, the load is sent straight to the cache. If a slice matches, a second cycle compares the full word address of every candidate. The outcome of that second check is one of three:

- The youngest true match has the same byte address and the same size, and the access is aligned: that store's data is forwarded.
- No candidate truly matches: the load is sent back to the cache path and pays the extra delay.
- The youngest true match overlaps the load in some other way: the load must wait until the store has drained.

Every result carries a kind code. The kind code shows which path the load took.

Top module: `store_fwd_buffer`

## Requirements
- R1: `st_ready` is high whenever fewer than DEPTH stores are held and low only when the buffer is full. A store is accepted on any cycle with `st_valid` and `st_ready` both high. A store offered while the buffer is full is not taken.
- R2: `wr_valid` is high exactly when the buffer holds a store. Stores leave in program order, one per cycle with `wr_ready` high. While `wr_ready` is low, `wr_addr`, `wr_size` and `wr_data` hold steady.
- R3: A probe whose key (address bits [13:2]) matches no held store returns a result one cycle after acceptance. The result has kind 0 (cache path) and data 0.
- R4: A probe whose key matches at least one held store drives `ld_ready` low for the next cycle. Its result appears two cycles after acceptance, and `ld_ready` then returns high.
- R5: The sizes are encoded 0 = byte, 1 = half, 2 = word and 3 = reserved. A probe is forwarded (kind 1, data taken from the store) when the youngest held store in the same word (address bits [31:2]) has an equal byte address and an equal size, and the address is aligned. Aligned means bit 0 is clear for a half and bits [1:0] are clear for a word.
- R6: A probe whose key matches but whose word address matches no held store returns kind 2 (replay through the cache) with data 0.
- R7: A probe returns kind 3 (wait for drain) with data 0 in either of two cases. The first is that the youngest same-word store differs in byte address or size. The second is that the two are equal but the access is misaligned or uses the reserved size.
- R8: When several held stores match, the youngest store older than the load supplies the result. A store accepted in the same cycle as the probe is not visible to that probe.
- R9: A store that drains to the cache in the same cycle as a probe still counts as held for that probe.
- R10: After reset the buffer is empty, `st_ready` and `ld_ready` are high, and `wr_valid` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer has room |
| st_addr | input | AW | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | DW | Store data, right-aligned |
| ld_valid | input | 1 | Load probe offered |
| ld_ready | output | 1 | Probe port can accept |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code |
| res_valid | output | 1 | Probe result present |
| res_kind | output | 2 | 0 cache, 1 forwarded, 2 replay, 3 wait |
| res_data | output | DW | Forwarded data, zero otherwise |
| wr_valid | output | 1 | Cache write request |
| wr_ready | input | 1 | Cache write port ready |
| wr_addr | output | AW | Cache write address |
| wr_size | output | 2 | Cache write size |
| wr_data | output | DW | Cache write data |

## Verification
The bench builds the block with its defaults: 8 entries, 32-bit addresses and data, and a 12-bit key. With these values eight stores fill the buffer, so the full-stall case is quick to reach. The key covers only address bits [13:2], so two addresses 0x4000 apart share a key but not a word. That makes the false-positive replay path easy to hit with plain addresses. Stores that share a word but differ in offset or size exercise the wait outcome. Timed probes cover the cases where a store enters or drains on the same edge as the probe.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RES_CACHE  = 2'd0,
    RES_FWD    = 2'd1,
    RES_REPLAY = 2'd2,
    RES_WAIT   = 2'd3
  } res_kind_e;

  // Natural alignment of an access, judged on its two low address bits.
  function automatic logic size_aligned(input logic [1:0] lo, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1'b1;
      SZ_HALF: return (lo[0] == 1'b0);
      SZ_WORD: return (lo == 2'b00);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sbf_queue.sv
module sbf_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [AW-1:0]   push_addr,
  input  logic [1:0]      push_size,
  input  logic [DW-1:0]   push_data,
  input  logic            wr_ready,
  output logic            full,
  output logic            pop,
  output logic [DEPTH-1:0] ent_valid,
  output logic [AW-1:0]   ent_addr [DEPTH],
  output logic [1:0]      ent_size [DEPTH],
  output logic [DW-1:0]   ent_data [DEPTH],
  output logic [PTRW-1:0] tail_ptr,
  output logic            wr_valid,
  output logic [AW-1:0]   wr_addr,
  output logic [1:0]      wr_size,
  output logic [DW-1:0]   wr_data
);

  logic [PTRW-1:0]  head_q, tail_q;
  logic [DEPTH-1:0] valid_q, valid_d;

  assign full      = valid_q[tail_q];
  assign wr_valid  = valid_q[head_q];
  assign pop       = wr_valid && wr_ready;
  assign ent_valid = valid_q;
  assign tail_ptr  = tail_q;
  assign wr_addr   = ent_addr[head_q];
  assign wr_size   = ent_size[head_q];
  assign wr_data   = ent_data[head_q];

  always_comb begin
    valid_d = valid_q;
    if (pop)  valid_d[head_q] = 1'b0;
    if (push) valid_d[tail_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[tail_q] <= push_addr;
      ent_size[tail_q] <= push_size;
      ent_data[tail_q] <= push_data;
    end
  end

endmodule

// File: rtl/sbf_probe.sv
module sbf_probe #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int PW    = 12,
  parameter int OFF   = 2,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             probe_fire,
  input  logic [AW-1:0]    ld_addr,
  input  logic [1:0]       ld_size,
  input  logic [DEPTH-1:0] ent_valid,
  input  logic [AW-1:0]    ent_addr [DEPTH],
  input  logic [PTRW-1:0]  tail_ptr,
  output logic             phit_any,
  output logic             s1_valid,
  output logic [DEPTH-1:0] s1_mask,
  output logic [AW-1:0]    s1_addr,
  output logic [1:0]       s1_size,
  output logic [PTRW-1:0]  s1_tail
);

  function automatic logic [PW-1:0] part_key(input logic [AW-1:0] a);
    return a[OFF +: PW];
  endfunction

  logic [DEPTH-1:0] phit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_key
    assign phit[i] = ent_valid[i] && (part_key(ent_addr[i]) == part_key(ld_addr));
  end

  assign phit_any = |phit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mask  <= '0;
      s1_addr  <= '0;
      s1_size  <= '0;
      s1_tail  <= '0;
    end else begin
      s1_valid <= probe_fire && phit_any;
      if (probe_fire) begin
        s1_mask <= phit;
        s1_addr <= ld_addr;
        s1_size <= ld_size;
        s1_tail <= tail_ptr;
      end
    end
  end

endmodule

// File: rtl/sbf_confirm.sv
module sbf_confirm import sbf_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int OFF   = 2,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] s1_mask,
  input  logic [AW-1:0]    s1_addr,
  input  logic [1:0]       s1_size,
  input  logic [PTRW-1:0]  s1_tail,
  input  logic [AW-1:0]    ent_addr [DEPTH],
  input  logic [1:0]       ent_size [DEPTH],
  input  logic [DW-1:0]    ent_data [DEPTH],
  output logic             conf_found,
  output logic [1:0]       conf_kind,
  output logic [DW-1:0]    conf_data
);

  function automatic logic [AW-OFF-1:0] word_key(input logic [AW-1:0] a);
    return a[AW-1:OFF];
  endfunction

  // Slot k places behind the captured tail (k = 1 is the youngest).
  function automatic logic [PTRW-1:0] back_idx(input logic [PTRW-1:0] t, input int k);
    return t - PTRW'(k);
  endfunction

  logic [PTRW-1:0] sel;
  logic            exact;

  always_comb begin
    conf_found = 1'b0;
    sel        = '0;
    for (int k = 1; k <= DEPTH; k++) begin
      if (!conf_found && s1_mask[back_idx(s1_tail, k)] &&
          word_key(ent_addr[back_idx(s1_tail, k)]) == word_key(s1_addr)) begin
        conf_found = 1'b1;
        sel        = back_idx(s1_tail, k);
      end
    end
  end

  assign exact = (ent_addr[sel] == s1_addr) && (ent_size[sel] == s1_size) &&
                 size_aligned(s1_addr[1:0], s1_size);

  always_comb begin
    conf_data = '0;
    if (!conf_found)  conf_kind = RES_REPLAY;
    else if (exact) begin
      conf_kind = RES_FWD;
      conf_data = ent_data[sel];
    end else          conf_kind = RES_WAIT;
  end

endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer import sbf_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  output logic          res_valid,
  output logic [1:0]    res_kind,
  output logic [DW-1:0] res_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [1:0]    wr_size,
  output logic [DW-1:0] wr_data
);

  localparam int PTRW = $clog2(DEPTH);
  localparam int OFF  = $clog2(DW / 8);

  // Named internal events, visible to the bound checker.
  logic             full, push, pop, probe_fire, phit_any;
  logic             s1_valid, conf_found;
  logic [DEPTH-1:0] ent_valid, s1_mask;
  logic [AW-1:0]    ent_addr [DEPTH];
  logic [1:0]       ent_size [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];
  logic [PTRW-1:0]  tail_ptr, s1_tail;
  logic [AW-1:0]    s1_addr;
  logic [1:0]       s1_size, conf_kind;
  logic [DW-1:0]    conf_data;

  assign st_ready   = !full;
  assign push       = st_valid && st_ready;
  assign ld_ready   = !s1_valid;
  assign probe_fire = ld_valid && ld_ready;

  sbf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(st_addr),
    .push_size(st_size), .push_data(st_data), .wr_ready(wr_ready),
    .full(full), .pop(pop), .ent_valid(ent_valid), .ent_addr(ent_addr),
    .ent_size(ent_size), .ent_data(ent_data), .tail_ptr(tail_ptr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data)
  );

  sbf_probe #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .OFF(OFF)) u_probe (
    .clk(clk), .rst_n(rst_n), .probe_fire(probe_fire), .ld_addr(ld_addr),
    .ld_size(ld_size), .ent_valid(ent_valid), .ent_addr(ent_addr),
    .tail_ptr(tail_ptr), .phit_any(phit_any), .s1_valid(s1_valid),
    .s1_mask(s1_mask), .s1_addr(s1_addr), .s1_size(s1_size), .s1_tail(s1_tail)
  );

  sbf_confirm #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .OFF(OFF)) u_confirm (
    .s1_mask(s1_mask), .s1_addr(s1_addr), .s1_size(s1_size), .s1_tail(s1_tail),
    .ent_addr(ent_addr), .ent_size(ent_size), .ent_data(ent_data),
    .conf_found(conf_found), .conf_kind(conf_kind), .conf_data(conf_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_kind  <= RES_CACHE;
      res_data  <= '0;
    end else begin
      res_valid <= s1_valid || (probe_fire && !phit_any);
      res_kind  <= s1_valid ? conf_kind : RES_CACHE;
      res_data  <= s1_valid ? conf_data : '0;
    end
  end

endmodule

// File: rtl/store_fwd_buffer_chk.sv
module store_fwd_buffer_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic          ld_valid,
  input logic          ld_ready,
  input logic          res_valid,
  input logic [1:0]    res_kind,
  input logic [DW-1:0] res_data,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [1:0]    wr_size,
  input logic [DW-1:0] wr_data,
  input logic          phit_any
);

  localparam int CW = $clog2(DEPTH + 1);

  // Occupancy rebuilt from the port handshakes alone.
  logic [CW-1:0] occ;
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + CW'(st_valid && st_ready) - CW'(wr_valid && wr_ready);
  end

  a_r1_ready_tracks_room: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready == (occ < CW'(DEPTH)));

  a_r2_valid_tracks_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid == (occ != '0));

  a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_size) && $stable(wr_data));

  a_r3_miss_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready && !phit_any |=> res_valid && res_kind == 2'd0);

  a_r4_hit_holds_port: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready && phit_any |=> !res_valid && !ld_ready);

  a_r4_confirm_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready |=> res_valid && ld_ready && res_kind != 2'd0);

  a_r7_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind != 2'd1 |-> res_data == '0);

  a_r10_result_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(ld_valid && ld_ready) || !$past(ld_ready));

endmodule

bind store_fwd_buffer store_fwd_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .res_valid(res_valid),
  .res_kind(res_kind), .res_data(res_data), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size),
  .wr_data(wr_data), .phit_any(phit_any)
);

// File: tb/store_fwd_buffer_tb.sv
module store_fwd_buffer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, st_ready;
  logic [31:0] st_addr = '0;
  logic [1:0]  st_size = '0;
  logic [31:0] st_data = '0;
  logic        ld_valid = 1'b0, ld_ready;
  logic [31:0] ld_addr = '0;
  logic [1:0]  ld_size = '0;
  logic        res_valid;
  logic [1:0]  res_kind;
  logic [31:0] res_data;
  logic        wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  store_fwd_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_size(ld_size),
    .res_valid(res_valid), .res_kind(res_kind), .res_data(res_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [1:0]  kind;
    logic [31:0] data;
    logic [1:0]  lat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_1000, 2'd2, 2'd1, 32'hAAAA_0002, 2'd2, 4'd8}, // R8 younger of two
    '{32'h0000_2004, 2'd1, 2'd1, 32'h0000_BEEF, 2'd2, 4'd5}, // R5 half
    '{32'h0000_3008, 2'd0, 2'd1, 32'h0000_00C3, 2'd2, 4'd5}, // R5 byte
    '{32'h0000_2004, 2'd2, 2'd3, 32'h0,         2'd2, 4'd7}, // R7 size differs
    '{32'h0000_2006, 2'd1, 2'd3, 32'h0,         2'd2, 4'd7}, // R7 offset differs
    '{32'h0000_3009, 2'd0, 2'd3, 32'h0,         2'd2, 4'd7}, // R7 byte offset
    '{32'h0000_600A, 2'd2, 2'd3, 32'h0,         2'd2, 4'd7}, // R7 misaligned
    '{32'h0000_700C, 2'd3, 2'd3, 32'h0,         2'd2, 4'd7}, // R7 reserved size
    '{32'h0000_1010, 2'd2, 2'd2, 32'h0,         2'd2, 4'd6}, // R6 aliases 0x5010
    '{32'h0000_9000, 2'd2, 2'd2, 32'h0,         2'd2, 4'd6}, // R6 aliases 0x1000
    '{32'h0000_0100, 2'd2, 2'd0, 32'h0,         2'd1, 4'd3}, // R3 no key
    '{32'h0000_7FFC, 2'd2, 2'd0, 32'h0,         2'd1, 4'd3}  // R3 top key
  };

  logic [31:0] sa [8];
  logic [1:0]  sz [8];
  logic [31:0] sd [8];

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic push(input int i);
    chk(st_ready === 1'b1, "R1 st_ready with room", 32'(st_ready), 32'd1);
    st_valid = 1'b1; st_addr = sa[i]; st_size = sz[i]; st_data = sd[i];
    @(posedge clk); @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic [1:0] s, input logic [1:0] k,
                       input logic [31:0] d, input int lat, input int req);
    chk(ld_ready === 1'b1, "R4 ld_ready before probe", 32'(ld_ready), 32'd1);
    ld_valid = 1'b1; ld_addr = a; ld_size = s;
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0;
    if (lat == 2) begin
      chk(res_valid === 1'b0 && ld_ready === 1'b0, "R4 hit pending after one cycle",
          {30'd0, res_valid, ld_ready}, 32'd0);
      @(posedge clk); @(negedge clk);
      chk(ld_ready === 1'b1, "R4 ld_ready restored", 32'(ld_ready), 32'd1);
    end
    chk(res_valid === 1'b1, $sformatf("R%0d result valid @%h", req, a), 32'(res_valid), 32'd1);
    chk(res_kind === k, $sformatf("R%0d kind @%h", req, a), 32'(res_kind), 32'(k));
    chk(res_data === d, $sformatf("R%0d data @%h", req, a), res_data, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    sa[0] = 32'h0000_1000; sz[0] = 2'd2; sd[0] = 32'hAAAA_0001;
    sa[1] = 32'h0000_2004; sz[1] = 2'd1; sd[1] = 32'h0000_BEEF;
    sa[2] = 32'h0000_1000; sz[2] = 2'd2; sd[2] = 32'hAAAA_0002;
    sa[3] = 32'h0000_3008; sz[3] = 2'd0; sd[3] = 32'h0000_00C3;
    sa[4] = 32'h0000_5010; sz[4] = 2'd2; sd[4] = 32'h1234_5678;
    sa[5] = 32'h0000_600A; sz[5] = 2'd2; sd[5] = 32'h0000_0055;
    sa[6] = 32'h0000_700C; sz[6] = 2'd3; sd[6] = 32'h0000_0077;
    sa[7] = 32'h0000_0A00; sz[7] = 2'd2; sd[7] = 32'h0000_0A00;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(st_ready === 1'b1, "R10 st_ready", 32'(st_ready), 32'd1);
    chk(ld_ready === 1'b1, "R10 ld_ready", 32'(ld_ready), 32'd1);
    chk(wr_valid === 1'b0, "R10 wr_valid", 32'(wr_valid), 32'd0);
    chk(res_valid === 1'b0, "R10 res_valid", 32'(res_valid), 32'd0);

    for (int i = 0; i < 7; i++) push(i);
    for (int i = 0; i < NV; i++)
      probe(VEC[i].addr, VEC[i].size, VEC[i].kind, VEC[i].data, int'(VEC[i].lat), int'(VEC[i].req));

    // R1: eighth store fills the buffer, a further one is refused
    push(7);
    chk(st_ready === 1'b0, "R1 full deasserts st_ready", 32'(st_ready), 32'd0);
    st_valid = 1'b1; st_addr = 32'hDEAD_0000; st_size = 2'd2; st_data = 32'hDEAD_DEAD;
    @(posedge clk); @(negedge clk);
    st_valid = 1'b0;

    // R2: held head while stalled, then program-order drain
    chk(wr_valid === 1'b1 && wr_addr === sa[0], "R2 head before stall", wr_addr, sa[0]);
    @(posedge clk); @(negedge clk);
    chk(wr_addr === sa[0] && wr_data === sd[0], "R2 head stable while stalled", wr_data, sd[0]);
    wr_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk(wr_valid === 1'b1, $sformatf("R2 wr_valid slot %0d", i), 32'(wr_valid), 32'd1);
      chk(wr_addr === sa[i] && wr_size === sz[i], $sformatf("R2 order addr %0d", i), wr_addr, sa[i]);
      chk(wr_data === sd[i], $sformatf("R2 order data %0d", i), wr_data, sd[i]);
      @(posedge clk); @(negedge clk);
      if (i == 0) chk(st_ready === 1'b1, "R1 room after one drain", 32'(st_ready), 32'd1);
    end
    wr_ready = 1'b0;
    chk(wr_valid === 1'b0, "R1 refused store not held", 32'(wr_valid), 32'd0);

    // R8: store entering on the probe's own edge is not seen
    st_valid = 1'b1; st_addr = 32'h0000_8880; st_size = 2'd2; st_data = 32'hCAFE_0001;
    ld_valid = 1'b1; ld_addr = 32'h0000_8880; ld_size = 2'd2;
    @(posedge clk); @(negedge clk);
    st_valid = 1'b0; ld_valid = 1'b0;
    chk(res_valid === 1'b1 && res_kind === 2'd0, "R8 same-edge store invisible",
        {30'd0, res_kind}, 32'd0);

    // R9: store drains on the same edge the probe is taken
    wr_ready = 1'b1;
    probe(32'h0000_8880, 2'd2, 2'd1, 32'hCAFE_0001, 2, 9);
    wr_ready = 1'b0;
    chk(wr_valid === 1'b0, "R9 store did drain", 32'(wr_valid), 32'd0);

    // R3 on an empty buffer
    probe(32'h0000_8880, 2'd2, 2'd0, 32'h0, 1, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule